// File: doc/BRIEF.md
# Maskable Twelve-Source Interrupt Status Unit

This unit collects one-cycle event pulses from a serial-highway message engine into a 12-bit status register, filters them through a 12-bit mask, and turns the result into a single interrupt request for a host. The host reaches the unit through a small byte-wide register bus. Through this bus the host can clear status bits, manage the mask, program an 8-bit interrupt vector and arm a global enable. When the host acknowledges the interrupt, the unit returns the vector and disarms itself. The host must then re-arm the enable explicitly before the next interrupt.

Each status bit has a fixed meaning tied to the outcome of a serial-highway transaction:

| Bit | Meaning |
|-----|---------|
| 0 | no-Q |
| 1 | no-X |
| 2 | command error |
| 3 | error in the previous command |
| 4 | address not recognised |
| 5 | longitudinal parity error |
| 6 | reply timeout |
| 7 | transverse parity error |
| 8 | ready |
| 9 | transmit done |
| 10 | demand received |
| 11 | sync lost |

The bus is 8 bits wide and carries 16-bit registers. The host first writes the upper byte, which the unit holds. The register action happens only when the following lower-byte write arrives. Register reads return all 16 bits at once, combinationally.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the status, mask and vector registers read 0, the global enable is 0, and `irq` is low.
- R2: An `evt_in[i]` pulse sets status bit i at the next clock edge. Bit positions follow the table above: bit 0 is no-Q and bit 11 is sync lost. The status register reads at address 3.
- R3: A lower-byte write to address 3 clears each status bit that is 1 in the 16-bit write word. A write to address 4 clears the whole status register.
- R4: When an event pulse and a host clear hit the same status bit in the same cycle, the event wins and the bit stays set.
- R5: The mask supports four actions. A write to address 5 loads the mask, and a read of address 5 returns it. A write to address 6 sets the given bits. A write to address 7 clears the given bits. A write to address 8 clears the whole mask.
- R6: `summary` is 1 exactly when some status bit has its mask bit set. It also reads at address 0 bit 0.
- R7: `irq` equals `summary` AND the global enable. A write to address 0 loads the enable from bit 7 of the write word. The enable reads back at address 0 bit 7.
- R8: While `iack` is high, `vec_out` carries the vector; otherwise `vec_out` is 0. The clock edge that samples `iack` clears the enable, so `irq` is low in the following cycle.
- R9: The vector is written at address 1 (lower 8 bits) and read back at address 2. Reading address 1 returns 0.
- R10: A write with `host_hi` set stores the upper byte and changes no register. The next lower-byte write uses that byte as bits 15:8 and then consumes it. A lower-byte write with no upper byte pending uses 0 for bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_hi | input | 1 | 1: this write carries the upper byte |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data for `host_addr` |
| evt_in | input | 12 | Event pulses, one per status bit |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| summary | output | 1 | Any masked status bit set |
| vec_out | output | 8 | Vector during acknowledge, else 0 |

## Verification
The bench pulses an event in the same cycle as a selective clear of that bit. A design that lets the clear win would drop the event. The bench also removes a mask bit while the status bit is still set; a design that latched the summary would keep `irq` asserted. It acknowledges and then checks that `irq` falls with the vector visible only during `iack`, which catches an enable that never self-clears. Finally, it issues lone upper-byte writes and unpaired lower-byte writes, which expose a design that acts on the upper byte early or reuses a stale upper byte.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NSRC = 12,
  parameter int VW   = 8,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            host_hi,
  input  logic [AW-1:0]   host_addr,
  input  logic [7:0]      host_wdata,
  output logic [15:0]     host_rdata,
  input  logic [NSRC-1:0] evt_in,
  input  logic            iack,
  output logic            irq,
  output logic            summary,
  output logic [VW-1:0]   vec_out
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_VWR = AW'(1), A_VRD = AW'(2),
                            A_SCLR = AW'(3), A_SALL = AW'(4), A_MWR = AW'(5),
                            A_MSET = AW'(6), A_MCLR = AW'(7), A_MALL = AW'(8);
  localparam int GIE_BIT = 7;

  logic [7:0]      hold_q;
  logic [NSRC-1:0] status_q, mask_q;
  logic [VW-1:0]   vec_q;
  logic            gie_q;

  wire             lo_wr = host_wr & ~host_hi;
  wire [15:0]      wd    = {hold_q, host_wdata};
  wire [NSRC-1:0]  wbits = wd[NSRC-1:0];

  logic [NSRC-1:0] st_clr;
  always_comb begin
    st_clr = '0;
    if (lo_wr && host_addr == A_SCLR) st_clr = wbits;
    if (lo_wr && host_addr == A_SALL) st_clr = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
      vec_q    <= '0;
      gie_q    <= 1'b0;
    end else begin
      if (host_wr && host_hi) hold_q <= host_wdata;
      else if (lo_wr)         hold_q <= '0;

      status_q <= (status_q & ~st_clr) | evt_in;

      if (lo_wr) begin
        case (host_addr)
          A_MWR:   mask_q <= wbits;
          A_MSET:  mask_q <= mask_q | wbits;
          A_MCLR:  mask_q <= mask_q & ~wbits;
          A_MALL:  mask_q <= '0;
          default: ;
        endcase
      end

      if (lo_wr && host_addr == A_VWR) vec_q <= wd[VW-1:0];

      if (iack)                              gie_q <= 1'b0;
      else if (lo_wr && host_addr == A_CTRL) gie_q <= wd[GIE_BIT];
    end
  end

  assign summary = |(status_q & mask_q);
  assign irq     = summary & gie_q;
  assign vec_out = iack ? vec_q : '0;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL: begin
        host_rdata[GIE_BIT] = gie_q;
        host_rdata[0]       = summary;
      end
      A_VRD:  host_rdata[VW-1:0]   = vec_q;
      A_SCLR: host_rdata[NSRC-1:0] = status_q;
      A_MWR:  host_rdata[NSRC-1:0] = mask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int NSRC = 12,
  parameter int VW   = 8,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_wr,
  input logic            host_hi,
  input logic [AW-1:0]   host_addr,
  input logic [NSRC-1:0] evt_in,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic [VW-1:0]   vec_q,
  input logic            iack,
  input logic            irq,
  input logic            summary,
  input logic [VW-1:0]   vec_out
);
  // R2 R4
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in)));
  // R8
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> !irq);
  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |-> (vec_out == '0));
  // R10
  hi_only_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_hi) |=> ($stable(mask_q) && $stable(vec_q)));
  // R5 R6
  mask_all_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_hi && host_addr == AW'(8)) |=> (mask_q == '0));
  // R7
  irq_needs_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> summary);
endmodule

bind irq_status_unit irq_status_unit_chk #(.NSRC(NSRC), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_hi(host_hi),
  .host_addr(host_addr), .evt_in(evt_in), .status_q(status_q),
  .mask_q(mask_q), .vec_q(vec_q), .iack(iack), .irq(irq),
  .summary(summary), .vec_out(vec_out)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_hi = 1'b0, iack = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] host_rdata;
  logic [11:0] evt_in = '0;
  logic        irq, summary;
  logic [7:0]  vec_out;
  int checks = 0, errors = 0;

  irq_status_unit u0 (.*);

  always #2 clk = ~clk;

  // {write addr, write word, read addr, expected read}
  localparam logic [39:0] TBL [6] = '{
    {4'd5, 16'h0A5F, 4'd5, 16'h0A5F},
    {4'd6, 16'h0100, 4'd5, 16'h0B5F},
    {4'd7, 16'h000F, 4'd5, 16'h0B50},
    {4'd1, 16'h00C3, 4'd2, 16'h00C3},
    {4'd8, 16'h0000, 4'd5, 16'h0000},
    {4'd5, 16'h0FFF, 4'd5, 16'h0FFF}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wbyte(input logic hi, input logic [3:0] a, input logic [7:0] d,
                       input logic [11:0] ev = '0);
    @(negedge clk);
    host_wr = 1'b1; host_hi = hi; host_addr = a; host_wdata = d; evt_in = ev;
    @(negedge clk);
    host_wr = 1'b0; host_hi = 1'b0; evt_in = '0;
  endtask

  task automatic wword(input logic [3:0] a, input logic [15:0] d);
    wbyte(1'b1, a, d[15:8]);
    wbyte(1'b0, a, d[7:0]);
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    host_addr = a;
    #1;
    chk(host_rdata, exp, tag);
  endtask

  task automatic pulse(input logic [11:0] ev);
    @(negedge clk); evt_in = ev;
    @(negedge clk); evt_in = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'd3, 16'h0, "R1 status");
    rd(4'd5, 16'h0, "R1 mask");
    rd(4'd2, 16'h0, "R1 vector");
    rd(4'd0, 16'h0, "R1 ctrl");
    chk({15'b0, irq}, 16'h0, "R1 irq");

    // R5 R9 R10 table of mask and vector actions
    for (int i = 0; i < 6; i++) begin
      wword(TBL[i][39:36], TBL[i][35:20]);
      rd(TBL[i][19:16], TBL[i][15:0], "R5/R9 table");
    end
    rd(4'd1, 16'h0, "R9 addr1 read");

    // R2 event sets bit 4 (address not recognised)
    pulse(12'h010);
    rd(4'd3, 16'h0010, "R2 bit4");
    // R6 summary with mask all ones, R7 enable still off
    rd(4'd0, 16'h0001, "R6 summary read");
    chk({15'b0, irq}, 16'h0, "R7 irq gated");
    wword(4'd0, 16'h0080);
    chk({15'b0, irq}, 16'h1, "R7 irq armed");
    rd(4'd0, 16'h0081, "R7 enable read");
    wword(4'd7, 16'h0010);
    chk({15'b0, summary}, 16'h0, "R6 mask removes");
    chk({15'b0, irq}, 16'h0, "R7 irq follows mask");
    wword(4'd6, 16'h0010);
    chk({15'b0, irq}, 16'h1, "R7 irq again");

    // R8 acknowledge
    chk({8'b0, vec_out}, 16'h0, "R8 vec idle");
    @(negedge clk); iack = 1'b1; #1;
    chk({8'b0, vec_out}, 16'h00C3, "R8 vec during ack");
    @(negedge clk); iack = 1'b0; #1;
    chk({15'b0, irq}, 16'h0, "R8 irq after ack");
    rd(4'd0, 16'h0001, "R8 enable cleared");

    // R3 selective and full clear, R2 bit 11 and bit 0
    wword(4'd3, 16'h0010);
    rd(4'd3, 16'h0000, "R3 selective clr");
    pulse(12'h801);
    rd(4'd3, 16'h0801, "R2 bits 11 and 0");
    wbyte(1'b0, 4'd3, 8'h01);
    rd(4'd3, 16'h0800, "R3 partial clr");
    wword(4'd4, 16'h0000);
    rd(4'd3, 16'h0000, "R3 full clr");

    // R4 event beats same-cycle clear
    pulse(12'h004);
    wbyte(1'b0, 4'd3, 8'h04, 12'h004);
    rd(4'd3, 16'h0004, "R4 event wins");
    wbyte(1'b0, 4'd4, 8'h00, 12'h004);
    rd(4'd3, 16'h0004, "R4 event wins full clr");

    // R10 upper byte hold
    wbyte(1'b1, 4'd5, 8'h0F);
    rd(4'd5, 16'h0FFF, "R10 hi alone no effect");
    wbyte(1'b0, 4'd5, 8'h00);
    rd(4'd5, 16'h0F00, "R10 paired write");
    wbyte(1'b0, 4'd5, 8'h01);
    rd(4'd5, 16'h0001, "R10 hold consumed");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'd5, 16'h0, "R1 mask after reset");
    rd(4'd2, 16'h0, "R1 vec after reset");
    rd(4'd3, 16'h0, "R1 status after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule